// File: doc/BRIEF.md
# Transmitter fail-safe supervisor

This block sits between the digital transmit path and a bus line driver and decides, clock by clock, whether the driver may run. It watches the transmit-data input, a standby request input, a main-supply low flag, an I/O-supply switch-off flag and an over-temperature flag. From these it derives the effective operating mode (normal, standby or off), a driver enable, and a gated copy of transmit data in which a disabled driver always sees recessive (high).

Three protections are combined. A dominant watchdog drops the driver when transmit data stays low for too long, and releases it as soon as transmit data goes high again. An over-temperature event latches the driver off, and the latch is released only once the flag has cleared and transmit data is high in the same clock. The supply flags override the requested mode: a switch-off flag forces the off state, a main-supply low flag forces standby, and while either is active the standby request input has no effect. Every timeout is a parameter counted in clock cycles.

Top module: `txfs_supervisor`

## Requirements
- R1: While reset is asserted and after its release with the standby request held high, the mode output is standby, the driver enable is low and the gated transmit data is high.
- R2: With both supply flags clear, the mode output becomes normal one clock after the standby request is low and standby one clock after it is high; in standby the driver enable is low and the gated data is high.
- R3: In normal mode with no latched fault the driver enable is high and the gated data equals transmit data in the same cycle.
- R4: When transmit data is sampled low on DOM_TIMEOUT consecutive clocks the driver stays enabled; on the DOM_TIMEOUT+1-th consecutive low sample the timeout latches, the driver enable goes low and the gated data is forced high.
- R5: A clock on which transmit data is sampled high clears the timeout latch and restarts the low count, so lows separated by a high never add up to a timeout.
- R6: One clock after the over-temperature flag is sampled high the driver enable is low and the gated data is high.
- R7: The thermal latch clears only on a clock where the over-temperature flag is low and transmit data is high; while transmit data stays low after the flag clears, the driver stays disabled.
- R8: With the switch-off flag clear, a high main-supply low flag forces standby one clock later and the standby request input is ignored until the flag clears.
- R9: A high switch-off flag forces the off state one clock later, taking priority over the main-supply low flag and over the standby request; the driver enable is then low.
- R10: The mode output is encoded 2'b00 normal, 2'b01 standby, 2'b10 off, and never takes 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_in | input | 1 | Transmit data, low = dominant |
| stby_req | input | 1 | Standby request, high = standby, low = normal |
| vmain_low | input | 1 | Main supply below the standby level |
| vio_off | input | 1 | I/O supply below the switch-off level |
| overtemp | input | 1 | Junction over-temperature flag |
| drv_en | output | 1 | Driver enable |
| mode_out | output | 2 | Effective mode: 00 normal, 01 standby, 10 off |
| tx_gated | output | 1 | Transmit data to the driver, high when disabled |

## Verification
The dominant watchdog expiry and the over-temperature latch can both take effect on the same clock, and both must then be released by the same rising transmit data. The bench holds transmit data low until the cycle where the watchdog expires and raises the over-temperature flag for exactly that cycle, then clears the flag while transmit data stays low. It judges that the driver stays off through that window and returns on the single clock after transmit data goes high, which is only correct if neither latch releases the other.

// File: rtl/txfs_pkg.sv
package txfs_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_STANDBY = 2'b01,
    MODE_OFF     = 2'b10
  } txfs_mode_e;

  // Priority: switch-off supply, then main-supply override, then request pin.
  function automatic txfs_mode_e pick_mode(input logic vio_off,
                                           input logic vmain_low,
                                           input logic stby_req);
    if (vio_off)                    return MODE_OFF;
    else if (vmain_low || stby_req) return MODE_STANDBY;
    else                            return MODE_NORMAL;
  endfunction

  // Driver may run only in normal mode with both fault latches clear.
  function automatic logic drive_ok(input txfs_mode_e mode,
                                    input logic tout,
                                    input logic therm);
    return (mode == MODE_NORMAL) && !tout && !therm;
  endfunction

endpackage

// File: rtl/txfs_dom_watchdog.sv
module txfs_dom_watchdog #(
  parameter int DOM_TIMEOUT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_in,
  output logic to_latched
);
  localparam int CW = $clog2(DOM_TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DOM_TIMEOUT);

  logic [CW-1:0] low_cnt;
  logic          dom_expire;

  assign dom_expire = !tx_in && (low_cnt == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt    <= '0;
      to_latched <= 1'b0;
    end else if (tx_in) begin
      low_cnt    <= '0;
      to_latched <= 1'b0;
    end else if (dom_expire) begin
      to_latched <= 1'b1;
    end else begin
      low_cnt <= low_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/txfs_thermal_latch.sv
module txfs_thermal_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic overtemp,
  input  logic tx_in,
  output logic th_latched
);
  logic th_release;

  assign th_release = !overtemp && tx_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          th_latched <= 1'b0;
    else if (overtemp)   th_latched <= 1'b1;
    else if (th_release) th_latched <= 1'b0;
  end
endmodule

// File: rtl/txfs_mode_ctrl.sv
module txfs_mode_ctrl
  import txfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vio_off,
  input  logic       vmain_low,
  input  logic       stby_req,
  output txfs_mode_e mode_q
);
  txfs_mode_e mode_d;

  assign mode_d = pick_mode(vio_off, vmain_low, stby_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_STANDBY;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/txfs_supervisor.sv
module txfs_supervisor
  import txfs_pkg::*;
#(
  parameter int DOM_TIMEOUT = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_in,
  input  logic       stby_req,
  input  logic       vmain_low,
  input  logic       vio_off,
  input  logic       overtemp,
  output logic       drv_en,
  output logic [1:0] mode_out,
  output logic       tx_gated
);
  txfs_mode_e mode_q;
  logic       to_latched;
  logic       th_latched;

  txfs_mode_ctrl u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .vio_off   (vio_off),
    .vmain_low (vmain_low),
    .stby_req  (stby_req),
    .mode_q    (mode_q)
  );

  txfs_dom_watchdog #(.DOM_TIMEOUT(DOM_TIMEOUT)) u_wdog (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_in      (tx_in),
    .to_latched (to_latched)
  );

  txfs_thermal_latch u_therm (
    .clk        (clk),
    .rst_n      (rst_n),
    .overtemp   (overtemp),
    .tx_in      (tx_in),
    .th_latched (th_latched)
  );

  assign drv_en   = drive_ok(mode_q, to_latched, th_latched);
  assign mode_out = mode_q;
  assign tx_gated = drv_en ? tx_in : 1'b1;
endmodule

// File: rtl/txfs_checker.sv
module txfs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_in,
  input logic       vio_off,
  input logic       vmain_low,
  input logic       overtemp,
  input logic       drv_en,
  input logic [1:0] mode_out,
  input logic       to_latched,
  input logic       th_latched
);
  // R10: encoding 2'b11 is never produced
  p_mode_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_out != 2'b11);

  // R9: switch-off flag wins over everything
  p_off_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vio_off |=> (mode_out == 2'b10) && !drv_en);

  // R8: main-supply low forces standby regardless of request
  p_stby_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!vio_off && vmain_low) |=> (mode_out == 2'b01));

  // R6: over-temperature drops the driver on the next clock
  p_overtemp_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overtemp |=> !drv_en);

  // R7: thermal latch holds while transmit data stays low
  p_therm_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (th_latched && !tx_in) |=> th_latched);

  // R4: timeout latch holds while transmit data stays low
  p_tout_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (to_latched && !tx_in) |=> to_latched);

  // R5: a high sample clears the timeout latch
  p_tx_high_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_in |=> !to_latched);
endmodule

bind txfs_supervisor txfs_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_in      (tx_in),
  .vio_off    (vio_off),
  .vmain_low  (vmain_low),
  .overtemp   (overtemp),
  .drv_en     (drv_en),
  .mode_out   (mode_out),
  .to_latched (to_latched),
  .th_latched (th_latched)
);

// File: tb/txfs_supervisor_test.sv
module txfs_supervisor_test;
  localparam int N = 20;
  localparam logic [1:0] M_NORM = 2'b00;
  localparam logic [1:0] M_STBY = 2'b01;
  localparam logic [1:0] M_OFF  = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_in = 1'b1, stby_req = 1'b1, vmain_low = 1'b0, vio_off = 1'b0, overtemp = 1'b0;
  logic drv_en, tx_gated;
  logic [1:0] mode_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  txfs_supervisor #(.DOM_TIMEOUT(N)) uut (
    .clk(clk), .rst_n(rst_n), .tx_in(tx_in), .stby_req(stby_req),
    .vmain_low(vmain_low), .vio_off(vio_off), .overtemp(overtemp),
    .drv_en(drv_en), .mode_out(mode_out), .tx_gated(tx_gated)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected outputs: mode, enable, gated data
  task automatic expect3(input string req, input logic [1:0] m, input logic en, input logic g);
    chk(req, "mode", mode_out, m);
    chk(req, "drv_en", drv_en, en);
    chk(req, "tx_gated", tx_gated, g);
  endtask

  task automatic t_reset;
    step(1);
    expect3("R1", M_STBY, 1'b0, 1'b1);
    rst_n = 1'b1;
    step(2);
    expect3("R1", M_STBY, 1'b0, 1'b1);
  endtask

  task automatic t_mode_select;
    stby_req = 1'b0; step(1);
    expect3("R2", M_NORM, 1'b1, 1'b1);
    stby_req = 1'b1; step(1);
    expect3("R2", M_STBY, 1'b0, 1'b1);
    stby_req = 1'b0; step(1);
    expect3("R2", M_NORM, 1'b1, 1'b1);
  endtask

  task automatic t_passthrough;
    tx_in = 1'b0; #1;
    expect3("R3", M_NORM, 1'b1, 1'b0);
    step(1);
    tx_in = 1'b1; #1;
    expect3("R3", M_NORM, 1'b1, 1'b1);
    step(1);
  endtask

  task automatic t_watchdog;
    tx_in = 1'b0;
    step(N);
    expect3("R4", M_NORM, 1'b1, 1'b0);
    step(1);
    expect3("R4", M_NORM, 1'b0, 1'b1);
    step(3);
    expect3("R4", M_NORM, 1'b0, 1'b1);
    tx_in = 1'b1; #1;
    chk("R5", "drv_en_before_edge", drv_en, 0);
    step(1);
    expect3("R5", M_NORM, 1'b1, 1'b1);
  endtask

  task automatic t_short_lows;
    for (int k = 0; k < 3; k++) begin
      tx_in = 1'b0; step(N);
      chk("R5", "drv_en_low_run", drv_en, 1);
      tx_in = 1'b1; step(1);
    end
    tx_in = 1'b0; step(1);
    expect3("R5", M_NORM, 1'b1, 1'b0);
    tx_in = 1'b1; step(1);
  endtask

  task automatic t_overtemp;
    overtemp = 1'b1; step(1);
    expect3("R6", M_NORM, 1'b0, 1'b1);
    overtemp = 1'b0; step(1);
    expect3("R7", M_NORM, 1'b1, 1'b1);
    overtemp = 1'b1; tx_in = 1'b0; step(1);
    expect3("R6", M_NORM, 1'b0, 1'b1);
    overtemp = 1'b0; step(3);
    expect3("R7", M_NORM, 1'b0, 1'b1);
    tx_in = 1'b1; step(1);
    expect3("R7", M_NORM, 1'b1, 1'b1);
  endtask

  task automatic t_collision;
    tx_in = 1'b0; step(N);
    chk("R4", "drv_en_pre", drv_en, 1);
    overtemp = 1'b1; step(1);
    expect3("R6", M_NORM, 1'b0, 1'b1);
    overtemp = 1'b0; step(2);
    expect3("R7", M_NORM, 1'b0, 1'b1);
    tx_in = 1'b1; step(1);
    expect3("R7", M_NORM, 1'b1, 1'b1);
  endtask

  task automatic t_vmain;
    vmain_low = 1'b1; step(1);
    expect3("R8", M_STBY, 1'b0, 1'b1);
    stby_req = 1'b1; step(1);
    chk("R8", "mode_req_high", mode_out, M_STBY);
    stby_req = 1'b0; step(2);
    chk("R8", "mode_req_low", mode_out, M_STBY);
    vmain_low = 1'b0; step(1);
    expect3("R8", M_NORM, 1'b1, 1'b1);
  endtask

  task automatic t_vio;
    vio_off = 1'b1; vmain_low = 1'b1; step(1);
    expect3("R9", M_OFF, 1'b0, 1'b1);
    vmain_low = 1'b0; stby_req = 1'b1; step(1);
    expect3("R9", M_OFF, 1'b0, 1'b1);
    stby_req = 1'b0; tx_in = 1'b0; #1;
    chk("R9", "tx_gated_low_tx", tx_gated, 1);
    step(1);
    chk("R10", "mode_off_code", mode_out, 2);
    tx_in = 1'b1; vmain_low = 1'b1; vio_off = 1'b0; step(1);
    expect3("R9", M_STBY, 1'b0, 1'b1);
    vmain_low = 1'b0; step(1);
    expect3("R10", M_NORM, 1'b1, 1'b1);
  endtask

  initial begin
    t_reset();
    t_mode_select();
    t_passthrough();
    t_watchdog();
    t_short_lows();
    t_overtemp();
    t_collision();
    t_vmain();
    t_vio();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule